// File: doc/BRIEF.md
# Angle-Keyed LED Row Scanner

This block feeds the LED driver tiles of a spinning RGB voxel plate. Each driver tile holds an 8x8 grid of RGB LEDs, and only one of its eight rows is lit at a time. Whenever the angle sensor reports a new plate position, the scanner refreshes the display. For each of the eight rows it fetches eight 24-bit voxels from a synchronous frame memory and shifts them out serially. It then latches them into the drivers and switches the line multiplexer over to that row.

The scan is keyed to the position strobe rather than running freely. Each strobe restarts the scan at row 0, so every plate angle receives a complete, freshly ordered 8-row pass. A strobe that arrives before the pass has finished cuts it short, restarts it at row 0 and sets a sticky overrun flag. The serial clock is derived from the system clock by a parameterised bit-period divider. The default of 5 system clocks per bit gives 10 MHz from a 50 MHz clock.

Top module: `row_scanner`

## Requirements
- R1: For every row the block sends 192 bits: voxels in column order 0 to 7, each as 24 bits taken MSB first from `pix_data`. Red is `pix_data[23:16]`, green is `[15:8]` and blue is `[7:0]`. `pix_addr` is `{row, column}`, with the row in bits 5:3. The memory returns the data one clock after the address.
- R2: Each serial bit lasts `BIT_CYCLES` system clocks. `ser_clk` is low for the first `BIT_CYCLES/2` clocks of the bit and high for the rest. `ser_data` holds steady while `ser_clk` is high.
- R3: After the 192nd bit of a row, `ser_latch` is high for exactly one bit period, and `ser_clk` stays low during that period.
- R4: `blank` rises when the latch pulse starts and stays high while `row_sel` changes to the latched row, which happens at the end of the pulse. `blank` falls one clock after that change, so no row is ever selected unblanked with stale data.
- R5: One position strobe yields rows 0 to 7 in ascending order. After row 7 the block goes idle: no further serial clock pulses, with row 7 selected and lit (`blank` low) until the next strobe.
- R6: A strobe that arrives during a scan abandons the current row, forces `blank` high on the next clock and restarts the data of row 0 from column 0. The abandoned row's partial bits are never latched.
- R7: `overrun` goes high on the clock after a strobe that arrives while a scan is in progress, and stays high until reset. A strobe that arrives after a completed scan leaves it low.
- R8: During reset `blank` is 1 and `ser_latch`, `ser_clk`, `ser_data`, `row_sel` and `overrun` are 0. After reset the block stays idle until the first strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_tick | input | 1 | One-clock strobe per new plate angle |
| pix_addr | output | 6 | Frame-memory address `{row, column}` |
| pix_data | input | 24 | Voxel colour, returned one clock after the address |
| ser_data | output | 1 | Serial colour data to the drivers |
| ser_clk | output | 1 | Serial shift clock to the drivers |
| ser_latch | output | 1 | Driver latch strobe |
| blank | output | 1 | Output blanking for the drivers |
| row_sel | output | 3 | Line multiplexer row select |
| overrun | output | 1 | Sticky flag: a strobe arrived before the scan finished |

## Verification
The strobe is taken on the next clock edge. `blank` and `overrun` respond on that edge, so the bench samples them at the falling edge that follows. The first data bit appears two clocks later, after the one-clock memory read. Bits are captured at each rising edge of `ser_clk`. The bench measures each bit period and high time, then compares the whole 192-bit row against an arithmetic model of the memory when `ser_latch` rises. It checks the latch width on the falling edge of `ser_latch` and the selected row one clock after the row change, on the falling edge of `blank`, so every check lands in the clock where its result is due.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;

    // Plate tile geometry.
    localparam int ROW_N  = 8;
    localparam int COL_N  = 8;
    localparam int CH_W   = 8;

    localparam int ROW_W  = $clog2(ROW_N);
    localparam int COL_W  = $clog2(COL_N);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int VOX_W  = 3 * CH_W;
    localparam int IDX_W  = $clog2(VOX_W);

    // One voxel as it leaves the frame memory; red is shifted first.
    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] grn;
        logic [CH_W-1:0] blu;
    } voxel_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_SHIFT,
        ST_LATCH,
        ST_UNBLANK
    } scan_st_e;

    // Number of system clocks the serial clock stays low in one bit.
    function automatic int low_cycles(input int bit_cycles);
        return bit_cycles / 2;
    endfunction

endpackage

// File: rtl/rs_bit_timer.sv
module rs_bit_timer
    import row_scan_pkg::*;
#(
    parameter int BIT_CYCLES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic bit_end,
    output logic clk_phase
);

    localparam int CNT_W  = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
    localparam int LOW_N  = low_cycles(BIT_CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt <= '0;
        end else if (cnt == CNT_W'(BIT_CYCLES - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign bit_end   = run && (cnt == CNT_W'(BIT_CYCLES - 1));
    assign clk_phase = run && (cnt >= CNT_W'(LOW_N));

endmodule

// File: rtl/rs_voxel_serializer.sv
module rs_voxel_serializer
    import row_scan_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   shift,
    input  voxel_t din,
    output logic   sdo,
    output logic   last_bit
);

    voxel_t           sr;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            idx <= '0;
        end else if (load) begin
            sr  <= din;
            idx <= '0;
        end else if (shift) begin
            sr  <= voxel_t'({sr[VOX_W-2:0], 1'b0});
            idx <= idx + 1'b1;
        end
    end

    assign sdo      = sr[VOX_W-1];
    assign last_bit = (idx == IDX_W'(VOX_W - 1));

endmodule

// File: rtl/row_scanner.sv
module row_scanner
    import row_scan_pkg::*;
#(
    parameter int BIT_CYCLES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pos_tick,
    output logic [ADDR_W-1:0] pix_addr,
    input  logic [VOX_W-1:0]  pix_data,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_latch,
    output logic              blank,
    output logic [ROW_W-1:0]  row_sel,
    output logic              overrun
);

    scan_st_e          st;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [ADDR_W-1:0] fetch;
    logic              prep_wait;
    logic              blank_q;
    logic [ROW_W-1:0]  row_sel_q;
    logic              ovr_q;

    logic bit_end, clk_phase, last_bit, sdo;
    logic timer_run, row_last, col_last, voxel_done;
    logic ld_first, ld_next, ld_row, ser_load, ser_shift;

    assign timer_run  = (st == ST_SHIFT) || (st == ST_LATCH);
    assign row_last   = (row == ROW_W'(ROW_N - 1));
    assign col_last   = (col == COL_W'(COL_N - 1));
    assign voxel_done = (st == ST_SHIFT) && bit_end && last_bit;

    // Loads: first voxel after the read delay, next voxel in a row,
    // first voxel of the following row once the current one is shown.
    assign ld_first  = (st == ST_PREP) && prep_wait;
    assign ld_next   = voxel_done && !col_last;
    assign ld_row    = (st == ST_UNBLANK) && !row_last;
    assign ser_load  = !pos_tick && (ld_first || ld_next || ld_row);
    assign ser_shift = !pos_tick && (st == ST_SHIFT) && bit_end && !last_bit;

    rs_bit_timer #(
        .BIT_CYCLES(BIT_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (timer_run),
        .restart   (pos_tick),
        .bit_end   (bit_end),
        .clk_phase (clk_phase)
    );

    rs_voxel_serializer u_ser (
        .clk      (clk),
        .rst      (rst),
        .load     (ser_load),
        .shift    (ser_shift),
        .din      (voxel_t'(pix_data)),
        .sdo      (sdo),
        .last_bit (last_bit)
    );

    // Fetch pointer runs one voxel ahead of the shifter.
    always_ff @(posedge clk) begin
        if (rst || pos_tick) begin
            fetch <= '0;
        end else if (ser_load) begin
            fetch <= fetch + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            row       <= '0;
            col       <= '0;
            prep_wait <= 1'b0;
            blank_q   <= 1'b1;
            row_sel_q <= '0;
            ovr_q     <= 1'b0;
        end else if (pos_tick) begin
            if (st != ST_IDLE) begin
                ovr_q   <= 1'b1;
                blank_q <= 1'b1;
            end
            st        <= ST_PREP;
            row       <= '0;
            col       <= '0;
            prep_wait <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_PREP: begin
                    if (prep_wait) begin
                        st <= ST_SHIFT;
                    end
                    prep_wait <= 1'b1;
                end
                ST_SHIFT: begin
                    if (voxel_done) begin
                        if (col_last) begin
                            st      <= ST_LATCH;
                            blank_q <= 1'b1;
                        end else begin
                            col <= col + 1'b1;
                        end
                    end
                end
                ST_LATCH: begin
                    if (bit_end) begin
                        row_sel_q <= row;
                        st        <= ST_UNBLANK;
                    end
                end
                ST_UNBLANK: begin
                    blank_q <= 1'b0;
                    if (row_last) begin
                        st <= ST_IDLE;
                    end else begin
                        row <= row + 1'b1;
                        col <= '0;
                        st  <= ST_SHIFT;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign pix_addr  = fetch;
    assign ser_data  = sdo;
    assign ser_clk   = (st == ST_SHIFT) && clk_phase;
    assign ser_latch = (st == ST_LATCH);
    assign blank     = blank_q;
    assign row_sel   = row_sel_q;
    assign overrun   = ovr_q;

endmodule

// File: rtl/rs_checker.sv
module rs_checker
    import row_scan_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pos_tick,
    input logic             ser_data,
    input logic             ser_clk,
    input logic             ser_latch,
    input logic             blank,
    input logic [ROW_W-1:0] row_sel,
    input logic             overrun
);

    // R4: the line multiplexer only moves while the drivers are blanked.
    p_rowsel_blanked_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(row_sel) |-> blank)
        else $error("row_sel changed with blank low");

    // R4: latching always happens with outputs blanked.
    p_latch_blanked_r4: assert property (@(posedge clk) disable iff (rst)
        ser_latch |-> blank)
        else $error("latch pulse without blank");

    // R3: no shift clock during the latch pulse.
    p_latch_no_clk_r3: assert property (@(posedge clk) disable iff (rst)
        ser_latch |-> !ser_clk)
        else $error("serial clock high during latch");

    // R2: data held steady while the serial clock is high.
    p_data_steady_r2: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> $stable(ser_data))
        else $error("serial data moved during clock high");

    // R7: overrun is sticky.
    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun)
        else $error("overrun cleared without reset");

    // R7: overrun only rises after a position strobe.
    p_overrun_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(pos_tick))
        else $error("overrun rose without a strobe");

endmodule

bind row_scanner rs_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .pos_tick  (pos_tick),
    .ser_data  (ser_data),
    .ser_clk   (ser_clk),
    .ser_latch (ser_latch),
    .blank     (blank),
    .row_sel   (row_sel),
    .overrun   (overrun)
);

// File: tb/sim_row_scanner.sv
`timescale 1ns/1ps
module sim_row_scanner;

    localparam int B = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pos_tick = 1'b0;
    logic [5:0]  pix_addr;
    logic [23:0] pix_data = '0;
    logic        ser_data, ser_clk, ser_latch, blank, overrun;
    logic [2:0]  row_sel;

    always #10 clk = ~clk;

    row_scanner #(.BIT_CYCLES(B)) u0 (
        .clk       (clk),
        .rst       (rst),
        .pos_tick  (pos_tick),
        .pix_addr  (pix_addr),
        .pix_data  (pix_data),
        .ser_data  (ser_data),
        .ser_clk   (ser_clk),
        .ser_latch (ser_latch),
        .blank     (blank),
        .row_sel   (row_sel),
        .overrun   (overrun)
    );

    // Arithmetic frame-memory contents.
    function automatic logic [23:0] pix(input logic [5:0] a);
        logic [7:0] x;
        x = {2'b00, a};
        return {x * 8'd5 + 8'd17, x ^ 8'hA5, 8'hFF - x * 8'd3};
    endfunction

    function automatic logic [191:0] row_bits(input int r);
        logic [191:0] acc;
        acc = '0;
        for (int c = 0; c < 8; c++) begin
            acc = (acc << 24) | {168'd0, pix(6'(r * 8 + c))};
        end
        return acc;
    endfunction

    always @(posedge clk) pix_data <= pix(pix_addr);

    // ---------------- output monitor ----------------
    int           mon_tests = 0, mon_fails = 0;
    int           mon_lat = 0, mon_nbits = 0;
    logic [191:0] bits;
    int           since, hi, latw, per_bad, hi_bad, latclk_bad;
    logic         p_sclk, p_latch, p_blank;

    task automatic mchk(input bit ok, input string tag, input logic [191:0] act,
                        input logic [191:0] exp);
        mon_tests++;
        if (!ok) begin
            mon_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            mon_lat = 0; mon_nbits = 0; bits = '0; since = 0; hi = 0; latw = 0;
            per_bad = 0; hi_bad = 0; latclk_bad = 0;
        end else begin
            since++;
            if (ser_clk && !p_sclk) begin
                if (mon_nbits > 0 && since != B) per_bad++;
                since = 0;
                bits = {bits[190:0], ser_data};
                mon_nbits++;
            end
            if (ser_clk) hi++;
            else if (p_sclk) begin
                if (hi != B - B / 2) hi_bad++;
                hi = 0;
            end
            if (ser_latch && ser_clk) latclk_bad++;
            if (ser_latch && !p_latch) begin
                mchk(mon_nbits == 192, "R3 bit count", 192'(mon_nbits), 192'd192);
                mchk(bits == row_bits(mon_lat), "R1 row data", bits, row_bits(mon_lat));
                mchk(per_bad == 0 && hi_bad == 0, "R2 bit timing", 192'(per_bad + hi_bad), 192'd0);
                mchk(blank == 1'b1, "R4 blank at latch", 192'(blank), 192'd1);
                mon_lat++;
                mon_nbits = 0; per_bad = 0; hi_bad = 0; latw = 0;
            end
            if (ser_latch) latw++;
            else if (p_latch) begin
                mchk(latw == B && latclk_bad == 0, "R3 latch width", 192'(latw), 192'(B));
                latclk_bad = 0;
            end
            if (!blank && p_blank) begin
                mchk(row_sel == 3'(mon_lat - 1), "R4 R5 row select",
                     192'(row_sel), 192'(mon_lat - 1));
            end
            if (pos_tick) begin
                mon_nbits = 0; mon_lat = 0; per_bad = 0; hi_bad = 0; hi = 0;
            end
        end
        p_sclk  = ser_clk;
        p_latch = ser_latch;
        p_blank = blank;
    end

    // ---------------- stimulus ----------------
    int tests = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #2 pos_tick = 1'b1;
        @(posedge clk); #2 pos_tick = 1'b0;
    endtask

    task automatic wait_rows(input int n);
        while (mon_lat < n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(blank == 1'b1, "R8 blank in reset", int'(blank), 1);
        chk(ser_latch == 1'b0, "R8 latch in reset", int'(ser_latch), 0);
        chk(ser_clk == 1'b0, "R8 sclk in reset", int'(ser_clk), 0);
        chk(ser_data == 1'b0, "R8 sdata in reset", int'(ser_data), 0);
        chk(row_sel == 3'd0, "R8 row in reset", int'(row_sel), 0);
        chk(overrun == 1'b0, "R8 overrun in reset", int'(overrun), 0);
        @(posedge clk); #2 rst = 1'b0;
        repeat (30) @(negedge clk);
        chk(mon_nbits == 0, "R8 idle before strobe", mon_nbits, 0);

        // Full scan from idle.
        tick();
        wait_rows(8);
        repeat (40) @(negedge clk);
        chk(blank == 1'b0, "R5 last row lit", int'(blank), 0);
        chk(row_sel == 3'd7, "R5 last row held", int'(row_sel), 7);
        chk(mon_nbits == 0, "R5 no clocks after scan", mon_nbits, 0);
        chk(overrun == 1'b0, "R7 no overrun on clean scan", int'(overrun), 0);

        // Second clean scan.
        tick();
        wait_rows(8);
        repeat (10) @(negedge clk);
        chk(overrun == 1'b0, "R7 strobe after completed scan", int'(overrun), 0);

        // Abort during row 3.
        tick();
        wait_rows(3);
        repeat (300) @(negedge clk);
        tick();
        @(negedge clk);
        chk(blank == 1'b1, "R6 blank on abort", int'(blank), 1);
        chk(overrun == 1'b1, "R7 overrun set", int'(overrun), 1);
        wait_rows(8);
        repeat (10) @(negedge clk);
        chk(mon_lat == 8, "R6 restarted scan complete", mon_lat, 8);
        chk(overrun == 1'b1, "R7 overrun sticky", int'(overrun), 1);

        // Reset clears the flag.
        @(posedge clk); #2 rst = 1'b1;
        repeat (2) @(posedge clk); #2 rst = 1'b0;
        @(negedge clk);
        chk(overrun == 1'b0, "R7 R8 cleared by reset", int'(overrun), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests + mon_tests, fails + mon_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed",
                     tests + mon_tests + 1, fails + mon_fails + 1);
            $finish;
        end
    end

endmodule